// File: doc/BRIEF.md
# Watchdog Event Reset Sequencer

This block turns a watchdog timeout pulse for one processor core into a timed pair of requests: a non-maskable interrupt and a local reset. A small control word, written and read through a plain register port, picks the output behaviour and sets the gap between the two requests. The block runs on a slow clock that is one sixth of the core clock. All delays are counted in cycles of that clock.

On a watchdog pulse the block sets a sticky status flag. In the interrupt-then-reset mode it raises the interrupt and waits a programmable power-of-two number of cycles. It then raises the local reset. Both requests stay high until software clears the status flag, and that clear also arms the block for the next event. A lock bit freezes the configuration fields. After the lock is set, only a reset undoes it.

Top module: `wdog_rst_seq`

## Requirements
- R1: After reset the control word reads 0x0000_0040: mode 000, delay code 100, lock 0, status 0. Both nmi_o and lrst_o are low.
- R2: The delay code d (bits [6:4]) sets the gap between the rise of nmi_o and the rise of lrst_o to exactly 2^(8+d) clock cycles, from 256 up to 32768. With the reset code 100 the gap is 4096 cycles.
- R3: With mode 100 (bits [2:0]), an armed event raises nmi_o in the cycle after the event is sampled. lrst_o stays low until the delay has elapsed.
- R4: Mode 001 raises only lrst_o, and mode 010 raises only nmi_o, each in the cycle after the event. Every other mode code, including 000, raises neither output.
- R5: A wd_evt_i pulse sets the status bit (bit 12, read-only). The bit stays set until it is cleared.
- R6: Writing 1 to bit 16 clears the status bit. Writing 0 there has no effect, and bit 16 always reads 0.
- R7: While the lock bit (bit 8) is 1, writes to mode, delay and lock are ignored. The status clear through bit 16 still works.
- R8: Once raised, nmi_o and lrst_o stay high until the status bit is cleared. The clear drops both outputs and re-arms the block. Events that arrive while the status bit is set start no new sequence.
- R9: The delay code is captured when nmi_o rises. Writes to the delay field during the wait do not change the gap.
- R10: All bits other than [2:0], [6:4], 8 and 12 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow clock (core clock / 6) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| wd_evt_i | input | 1 | Single-cycle watchdog timeout pulse |
| nmi_o | output | 1 | Non-maskable interrupt request |
| lrst_o | output | 1 | Local core reset request |

## Verification
The table-driven part of the bench fires one event under each of the eight mode codes with the shortest delay. This separates the three active modes from each other and from the five inert codes. For mode 100 it also confirms that the reset request arrives exactly 256 cycles after the interrupt, not one cycle early or late. Directed runs cover the following cases:
- the default 4096-cycle gap;
- a delay write and a repeat event during a 512-cycle wait, which must not move the reset edge;
- an all-ones write, which separates reserved bits from real fields;
- a locked control word, which must reject configuration writes but still accept a status clear.

// File: rtl/wdrs_pkg.sv
package wdrs_pkg;
  localparam int MODE_W   = 3;
  localparam int DLY_W    = 3;
  localparam int DLY_BASE = 8;
  localparam int CNT_W    = DLY_BASE + (1 << DLY_W) - 1;

  localparam int MODE_LSB = 0;
  localparam int DLY_LSB  = 4;
  localparam int LOCK_BIT = 8;
  localparam int STAT_BIT = 12;
  localparam int CLR_BIT  = 16;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'b000;
  localparam logic [MODE_W-1:0] MODE_RST = 3'b001;
  localparam logic [MODE_W-1:0] MODE_NMI = 3'b010;
  localparam logic [MODE_W-1:0] MODE_SEQ = 3'b100;
  localparam logic [DLY_W-1:0]  DLY_RST  = 3'b100;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} seq_state_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [DLY_W-1:0]  dly;
    logic              lock;
  } ctrl_t;
endpackage

// File: rtl/wdrs_regs.sv
module wdrs_regs
  import wdrs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        evt_i,
  output ctrl_t       ctrl_o,
  output logic        status_o,
  output logic        clr_o,
  output logic [31:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  status_q;

  assign clr_o = we_i & wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.mode <= MODE_OFF;
      ctrl_q.dly  <= DLY_RST;
      ctrl_q.lock <= 1'b0;
      status_q    <= 1'b0;
    end else begin
      if (we_i && !ctrl_q.lock) begin
        ctrl_q.mode <= wdata_i[MODE_LSB +: MODE_W];
        ctrl_q.dly  <= wdata_i[DLY_LSB +: DLY_W];
        ctrl_q.lock <= wdata_i[LOCK_BIT];
      end
      // an event in the same cycle as a clear wins
      status_q <= evt_i | (status_q & ~clr_o);
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[MODE_LSB +: MODE_W]   = ctrl_q.mode;
    rdata_o[DLY_LSB +: DLY_W]     = ctrl_q.dly;
    rdata_o[LOCK_BIT]             = ctrl_q.lock;
    rdata_o[STAT_BIT]             = status_q;
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
endmodule

// File: rtl/wdrs_dly_cnt.sv
module wdrs_dly_cnt #(
  parameter int DLY_W    = 3,
  parameter int DLY_BASE = 8,
  localparam int CNT_W   = DLY_BASE + (1 << DLY_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [DLY_W-1:0] code_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] load_val;

  // 2^(base+code) cycles: count from span-1 down to 0
  always_comb begin
    span     = (CNT_W+1)'(1) << (DLY_BASE + int'(code_i));
    load_val = span[CNT_W-1:0] - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/wdrs_seq.sv
module wdrs_seq
  import wdrs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              status_i,
  input  logic              clr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              done_i,
  output logic              load_o,
  output logic              abort_o,
  output logic              nmi_o,
  output logic              lrst_o
);
  seq_state_e st_q;
  logic       nmi_q, lrst_q, start;

  assign start   = (st_q == ST_IDLE) && evt_i && !status_i && !clr_i;
  assign load_o  = start && (mode_i == MODE_SEQ);
  assign abort_o = clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nmi_q  <= 1'b0;
      lrst_q <= 1'b0;
    end else if (clr_i) begin
      st_q   <= ST_IDLE;
      nmi_q  <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          unique case (mode_i)
            MODE_SEQ: begin nmi_q  <= 1'b1; st_q <= ST_WAIT; end
            MODE_RST: begin lrst_q <= 1'b1; st_q <= ST_HOLD; end
            MODE_NMI: begin nmi_q  <= 1'b1; st_q <= ST_HOLD; end
            default:  ;
          endcase
        end
        ST_WAIT: if (done_i) begin
          lrst_q <= 1'b1;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign nmi_o  = nmi_q;
  assign lrst_o = lrst_q;
endmodule

// File: rtl/wdog_rst_seq.sv
module wdog_rst_seq
  import wdrs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        wd_evt_i,
  output logic        nmi_o,
  output logic        lrst_o
);
  ctrl_t ctrl;
  logic  status, clr, load, abort, done;

  wdrs_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .evt_i    (wd_evt_i),
    .ctrl_o   (ctrl),
    .status_o (status),
    .clr_o    (clr),
    .rdata_o  (reg_rdata_o)
  );

  wdrs_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (wd_evt_i),
    .status_i (status),
    .clr_i    (clr),
    .mode_i   (ctrl.mode),
    .done_i   (done),
    .load_o   (load),
    .abort_o  (abort),
    .nmi_o    (nmi_o),
    .lrst_o   (lrst_o)
  );

  wdrs_dly_cnt #(.DLY_W(DLY_W), .DLY_BASE(DLY_BASE)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .abort_i (abort),
    .code_i  (ctrl.dly),
    .done_o  (done)
  );
endmodule

// File: rtl/wdrs_chk.sv
module wdrs_chk
  import wdrs_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        wd_evt_i,
  input logic        nmi_o,
  input logic        lrst_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && reg_wdata_i[CLR_BIT];

  AST_NMI_LEADS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrst_o) && nmi_o |-> $past(nmi_o)); // R3
  AST_EVT_SETS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_evt_i |=> reg_rdata_o[STAT_BIT]); // R5
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[STAT_BIT] && !clr_wr |=> reg_rdata_o[STAT_BIT]); // R5
  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !reg_rdata_o[CLR_BIT]); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[LOCK_BIT] && reg_we_i |=> $stable(reg_rdata_o[LOCK_BIT:0])); // R7
  AST_CLR_DROPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !wd_evt_i |=> !nmi_o && !lrst_o && !reg_rdata_o[STAT_BIT]); // R8
  AST_NMI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && !clr_wr |=> nmi_o); // R8
  AST_LRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_o && !clr_wr |=> lrst_o); // R8
endmodule

bind wdog_rst_seq wdrs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .wd_evt_i    (wd_evt_i),
  .nmi_o       (nmi_o),
  .lrst_o      (lrst_o)
);

// File: tb/wdog_rst_seq_tb.sv
`timescale 1ns/1ps
module wdog_rst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        evt = 1'b0;
  logic        nmi, lrst;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_rst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wd_evt_i(evt), .nmi_o(nmi), .lrst_o(lrst)
  );

  // {mode, nmi after event, lrst after event, two-step sequence}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0, 1'b0},
    {3'b001, 1'b0, 1'b1, 1'b0},
    {3'b010, 1'b1, 1'b0, 1'b0},
    {3'b011, 1'b0, 1'b0, 1'b0},
    {3'b100, 1'b1, 1'b0, 1'b1},
    {3'b101, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b0, 1'b0, 1'b0},
    {3'b111, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [31:0] word(input logic [2:0] m, input logic [2:0] d,
                                       input logic lk, input logic st);
    word = '0;
    word[2:0] = m; word[6:4] = d; word[8] = lk; word[12] = st;
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d; tick(); we = 1'b0; wdata = '0;
  endtask

  task automatic pulse();
    evt = 1'b1; tick(); evt = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    do_reset();
    chk("R1", "reset word", rdata, 32'h0000_0040);
    chk("R1", "reset outputs", {30'd0, nmi, lrst}, 32'd0);

    // table walk: every mode, delay code 0
    for (int v = 0; v < 8; v++) begin
      logic [2:0] m;
      m = VEC[v][5:3];
      wr(word(m, 3'd0, 1'b0, 1'b0));
      pulse();
      chk("R4", $sformatf("mode %0d nmi", m), {31'd0, nmi}, {31'd0, VEC[v][2]});
      chk("R4", $sformatf("mode %0d lrst", m), {31'd0, lrst}, {31'd0, VEC[v][1]});
      chk("R5", "status set", {31'd0, rdata[12]}, 32'd1);
      if (VEC[v][0]) begin
        tick(254);
        chk("R3", "lrst low before delay", {30'd0, nmi, lrst}, 32'd2);
        tick();
        chk("R2", "lrst at 256", {30'd0, nmi, lrst}, 32'd2);
        tick();
        chk("R2", "lrst at 256", {30'd0, nmi, lrst}, 32'd3);
      end
      wr(word(m, 3'd0, 1'b0, 1'b0) | 32'h0001_0000);
      chk("R8", "clear drops outputs", {30'd0, nmi, lrst}, 32'd0);
      chk("R6", "status cleared, clear bit reads 0", rdata, word(m, 3'd0, 1'b0, 1'b0));
    end

    // default delay of 4096
    do_reset();
    wr(word(3'b100, 3'b100, 1'b0, 1'b0));
    pulse();
    tick(4095);
    chk("R2", "default gap lrst low", {31'd0, lrst}, 32'd0);
    tick();
    chk("R2", "default gap lrst at 4096", {31'd0, lrst}, 32'd1);

    // R9: delay captured; delay write and repeat event mid-wait
    wr(word(3'b100, 3'd1, 1'b0, 1'b0) | 32'h0001_0000);
    pulse();
    tick(10);
    wr(word(3'b100, 3'd7, 1'b0, 1'b0));
    pulse();
    tick(499);
    chk("R9", "lrst low at 511", {30'd0, nmi, lrst}, 32'd2);
    tick();
    chk("R9", "lrst at 512", {30'd0, nmi, lrst}, 32'd3);

    // R8: held outputs, events ignored while status set
    wr(word(3'b010, 3'd0, 1'b0, 1'b0) | 32'h0001_0000);
    pulse();
    pulse();
    tick(50);
    chk("R8", "nmi held, no new sequence", {30'd0, nmi, lrst}, 32'd2);
    wr(word(3'b001, 3'd0, 1'b0, 1'b0));
    pulse();
    chk("R8", "status set blocks new event", {30'd0, nmi, lrst}, 32'd2);
    wr(word(3'b001, 3'd0, 1'b0, 1'b0));
    chk("R6", "write 0 to clear keeps status", {31'd0, rdata[12]}, 32'd1);
    wr(word(3'b001, 3'd0, 1'b0, 1'b0) | 32'h0001_0000);
    pulse();
    chk("R8", "re-armed after clear", {30'd0, nmi, lrst}, 32'd1);

    // R10 reserved bits, then R7 lock
    do_reset();
    wr(32'hFFFF_FFFF);
    chk("R10", "all-ones write", rdata, word(3'b111, 3'b111, 1'b1, 1'b0));
    wr(32'h0000_0000);
    chk("R7", "locked fields unchanged", rdata, word(3'b111, 3'b111, 1'b1, 1'b0));
    pulse();
    chk("R7", "status set under lock", {31'd0, rdata[12]}, 32'd1);
    chk("R4", "inert mode 111", {30'd0, nmi, lrst}, 32'd0);
    wr(32'h0001_0000);
    chk("R7", "clear works under lock", rdata, word(3'b111, 3'b111, 1'b1, 1'b0));

    done = 1'b1;
    finish_run();
  end
endmodule